// File: doc/BRIEF.md
# Camera Frame-Sync Pulse Generator

This block drives the frame-sync line of an image sensor. It watches two timing strobes that arrive from outside the system clock domain, a vertical strobe and a horizontal strobe, and brings each through a two-stage synchronizer before it looks for edges. When generation is enabled, a vertical-strobe edge of the chosen direction starts a three-step sequence: a hold step, then active step 0, then active step 1. After active step 1 the block goes back to idle and waits for the next chosen vertical edge.

Every step drives the output at its own programmable level. Step lengths are counted in horizontal periods, one per detected active horizontal edge. The hold length comes from an 11-bit field, and the horizontal polarity setting changes how that field is read. With normal polarity the block counts rising horizontal edges and the hold lasts one period less than programmed. With inverted polarity it counts falling edges and the hold lasts exactly the programmed number. The two active steps each take their own 11-bit length. All settings are flat configuration inputs, held steady by the surrounding logic.

Top module: `fsync_pulse_gen`

## Requirements
- R1: After reset the block is idle. While idle, `fsync_out` equals `lvl_hold`, so with all configuration inputs at 0 it reads 0.
- R2: While `gen_en` is 0 no vertical edge starts a sequence. Dropping `gen_en` during a sequence returns the block to idle at the next clock edge. Horizontal edges seen afterwards do not move the output off `lvl_hold`.
- R3: With `vs_rise_sel` = 1 only a rising edge of `vsync_in` starts a sequence, and with 0 only a falling edge does. An edge in the other direction leaves the block idle.
- R4: A sequence always runs hold, then step 0, then step 1, then idle. `fsync_out` shows `lvl_hold`, then `lvl_ph0`, then `lvl_ph1`, then `lvl_hold` again.
- R5: With `hs_invert` = 0, rising edges of `hsync_in` are counted and the hold step lasts `hold_time`−1 of them. A `hold_time` of 0 or 1 skips the hold step, and the start edge leads straight into step 0 with no wrap-around.
- R6: With `hs_invert` = 1, falling edges of `hsync_in` are counted and the hold step lasts exactly `hold_time` of them. A value of 0 leads straight into step 0.
- R7: Step 0 lasts `ph0_time` counted horizontal edges and step 1 lasts `ph1_time`, counted on the same edge direction as the hold step. A length of 0 holds that step for one clock.
- R8: A vertical edge that arrives while a sequence is running has no effect on the sequence.
- R9: The strobe inputs pass through two synchronizer flops. If `vsync_in` changes just after clock edge 0 and starts a sequence whose hold is skipped, `fsync_out` still shows the old level after edge 2 and the new level after edge 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_en | input | 1 | Enables generation. 0 keeps or forces the block idle |
| vs_rise_sel | input | 1 | 1 selects the rising vertical edge as the start, 0 the falling edge |
| hs_invert | input | 1 | 1 inverts the horizontal strobe before counting |
| lvl_hold | input | 1 | Output level while idle and during the hold step |
| lvl_ph0 | input | 1 | Output level during active step 0 |
| lvl_ph1 | input | 1 | Output level during active step 1 |
| hold_time | input | 11 | Programmed hold length, in horizontal periods |
| ph0_time | input | 11 | Length of active step 0, in horizontal periods |
| ph1_time | input | 11 | Length of active step 1, in horizontal periods |
| vsync_in | input | 1 | Asynchronous vertical strobe |
| hsync_in | input | 1 | Asynchronous horizontal strobe |
| fsync_out | output | 1 | Frame-sync output to the sensor |

## Verification
A sequencer stuck in the wrong step shows up at the output within one horizontal period. The output level then differs from the level the programmed edge count predicts at the next sample after an active horizontal edge. A step counter that is off by one moves each level change by a whole horizontal period, and the off-by-one cases of the hold length expose this most clearly. A missed return to idle, whether after a sequence ends or after the enable drops, appears as a level other than the hold level while later horizontal edges arrive. Synchronizer latency errors show as the output changing one edge early or late after a vertical edge.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
    // width of every length field and step counter
    localparam int unsigned LEN_W = 11;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_PH0  = 2'd2,
        ST_PH1  = 2'd3
    } step_e;

    typedef struct packed {
        step_e            st;
        logic [LEN_W-1:0] cnt;
    } seq_t;
endpackage

// File: rtl/fsg_edge_sync.sv
module fsg_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic fall_sel,
    output logic pulse
);
    localparam int unsigned MSB = STAGES - 1;

    typedef struct packed {
        logic [MSB:0] sh;
        logic         prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d      = q;
        d.sh   = {q.sh[MSB-1:0], din};
        d.prev = q.sh[MSB];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pulse = fall_sel ? (q.prev & ~q.sh[MSB]) : (~q.prev & q.sh[MSB]);

    // R9: a detected edge lasts a single clock
    one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> (!pulse || $changed(fall_sel)));
endmodule

// File: rtl/fsg_phase_seq.sv
module fsg_phase_seq
    import fsg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             vs_pulse,
    input  logic             hs_pulse,
    input  logic [LEN_W-1:0] hold_len,
    input  logic [LEN_W-1:0] ph0_len,
    input  logic [LEN_W-1:0] ph1_len,
    output step_e            st
);
    seq_t             q, d;
    logic [LEN_W-1:0] lim;

    always_comb begin
        unique case (q.st)
            ST_HOLD: lim = hold_len;
            ST_PH0:  lim = ph0_len;
            ST_PH1:  lim = ph1_len;
            default: lim = '0;
        endcase
    end

    always_comb begin
        d = q;
        if (q.st == ST_IDLE) begin
            if (vs_pulse) begin
                d.cnt = '0;
                d.st  = (hold_len == '0) ? ST_PH0 : ST_HOLD;
            end
        end else if (q.cnt == lim) begin
            d.cnt = '0;
            unique case (q.st)
                ST_HOLD: d.st = ST_PH0;
                ST_PH0:  d.st = ST_PH1;
                default: d.st = ST_IDLE;
            endcase
        end else if (hs_pulse) begin
            d.cnt = q.cnt + 1'b1;
        end
        if (!en) begin
            d.st  = ST_IDLE;
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, cnt: '0};
        else        q <= d;
    end

    assign st = q.st;

    // R2
    en_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (q.st == ST_IDLE));
    // R4
    hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.st == ST_HOLD) |-> $past(q.st == ST_IDLE));
    // R4
    ph1_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.st == ST_PH1) |-> $past(q.st == ST_PH0));
    // R8
    busy_ignore_vs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vs_pulse && en && q.st == ST_PH0 && q.cnt != ph0_len) |=> (q.st == ST_PH0));
endmodule

// File: rtl/fsync_pulse_gen.sv
module fsync_pulse_gen
    import fsg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_en,
    input  logic             vs_rise_sel,
    input  logic             hs_invert,
    input  logic             lvl_hold,
    input  logic             lvl_ph0,
    input  logic             lvl_ph1,
    input  logic [LEN_W-1:0] hold_time,
    input  logic [LEN_W-1:0] ph0_time,
    input  logic [LEN_W-1:0] ph1_time,
    input  logic             vsync_in,
    input  logic             hsync_in,
    output logic             fsync_out
);
    localparam logic [LEN_W-1:0] ONE = {{(LEN_W-1){1'b0}}, 1'b1};

    logic             vs_edge, hs_edge;
    logic [LEN_W-1:0] hold_eff;
    step_e            st;

    fsg_edge_sync #(.STAGES(2)) u_vs (
        .clk(clk), .rst_n(rst_n), .din(vsync_in),
        .fall_sel(~vs_rise_sel), .pulse(vs_edge)
    );

    fsg_edge_sync #(.STAGES(2)) u_hs (
        .clk(clk), .rst_n(rst_n), .din(hsync_in),
        .fall_sel(hs_invert), .pulse(hs_edge)
    );

    // normal polarity loses one period; zero saturates instead of wrapping
    always_comb begin
        if (hs_invert)              hold_eff = hold_time;
        else if (hold_time == '0)   hold_eff = '0;
        else                        hold_eff = hold_time - ONE;
    end

    fsg_phase_seq u_seq (
        .clk(clk), .rst_n(rst_n), .en(gen_en),
        .vs_pulse(vs_edge), .hs_pulse(hs_edge),
        .hold_len(hold_eff), .ph0_len(ph0_time), .ph1_len(ph1_time),
        .st(st)
    );

    always_comb begin
        unique case (st)
            ST_PH0:  fsync_out = lvl_ph0;
            ST_PH1:  fsync_out = lvl_ph1;
            default: fsync_out = lvl_hold;
        endcase
    end
endmodule

// File: tb/tb_fsync_pulse_gen.sv
`timescale 1ns/1ps
module tb_fsync_pulse_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gen_en = 1'b0, vs_rise_sel = 1'b0, hs_invert = 1'b0;
    logic        lvl_hold = 1'b0, lvl_ph0 = 1'b0, lvl_ph1 = 1'b0;
    logic [10:0] hold_time = '0, ph0_time = '0, ph1_time = '0;
    logic        vsync_in = 1'b0, hsync_in = 1'b0;
    logic        fsync_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    fsync_pulse_gen dut (
        .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .vs_rise_sel(vs_rise_sel),
        .hs_invert(hs_invert), .lvl_hold(lvl_hold), .lvl_ph0(lvl_ph0),
        .lvl_ph1(lvl_ph1), .hold_time(hold_time), .ph0_time(ph0_time),
        .ph1_time(ph1_time), .vsync_in(vsync_in), .hsync_in(hsync_in),
        .fsync_out(fsync_out)
    );

    // {lvl_hold, lvl_ph0, lvl_ph1, hs_invert, vs_rise_sel, hold, ph0, ph1}
    localparam int NV = 6;
    localparam logic [37:0] VEC [NV] = '{
        {1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 11'd4, 11'd3, 11'd2},
        {1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 11'd2, 11'd2, 11'd3},
        {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 11'd0, 11'd2, 11'd1},
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 11'd1, 11'd1, 11'd2},
        {1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 11'd0, 11'd3, 11'd1},
        {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 11'd5, 11'd1, 11'd1}
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input logic exp, input string tag);
        checks++;
        if (fsync_out !== exp) begin
            failures++;
            $display("FAIL %s: fsync_out=%b expected=%b at %0t", tag, fsync_out, exp, $time);
        end
    endtask

    // one horizontal period: high half then low half
    task automatic hs_period(input logic pol, input logic exp, input string tag);
        hsync_in = 1'b1;
        tick(6);
        if (!pol) check(exp, tag);
        tick(2);
        hsync_in = 1'b0;
        tick(6);
        if (pol) check(exp, tag);
        tick(2);
    endtask

    task automatic run_frame(input logic [37:0] v);
        int  t, a, b, eff, total;
        logic pre, post, e;
        string tag;
        lvl_hold = v[37]; lvl_ph0 = v[36]; lvl_ph1 = v[35];
        hs_invert = v[34]; vs_rise_sel = v[33];
        hold_time = v[32:22]; ph0_time = v[21:11]; ph1_time = v[10:0];
        t = int'(v[32:22]); a = int'(v[21:11]); b = int'(v[10:0]);
        eff = hs_invert ? t : ((t == 0) ? 0 : t - 1);
        total = eff + a + b + 1;
        post = vs_rise_sel;
        pre  = ~vs_rise_sel;
        gen_en = 1'b1;
        vsync_in = pre;             // edge of the unselected direction
        tick(6);
        check(lvl_hold, "R3 unselected edge leaves idle");
        vsync_in = post;            // selected edge
        tick(6);
        if (eff == 0) check(lvl_ph0, hs_invert ? "R6 zero hold" : "R5 hold skipped");
        else          check(lvl_hold, "R4 hold level after start");
        for (int k = 1; k <= total; k++) begin
            if (k < eff)               begin e = lvl_hold; tag = hs_invert ? "R6 hold count" : "R5 hold count"; end
            else if (k < eff + a)      begin e = lvl_ph0;  tag = "R7 step0 count"; end
            else if (k < eff + a + b)  begin e = lvl_ph1;  tag = "R7 step1 count"; end
            else                       begin e = lvl_hold; tag = "R4 back to idle"; end
            hs_period(hs_invert, e, tag);
            if (k == 1) begin       // R8: re-fire vsync mid-sequence
                vsync_in = pre;  tick(3);
                vsync_in = post; tick(3);
                check(e, "R8 vsync while busy");
            end
        end
    endtask

    initial begin
        tick(3);
        check(1'b0, "R1 output in reset");
        rst_n = 1'b1;
        tick(4);
        check(1'b0, "R1 idle after reset");
        lvl_hold = 1'b1;
        tick(1);
        check(1'b1, "R1 idle shows hold level");

        for (int i = 0; i < NV; i++) run_frame(VEC[i]);

        // R2: disabled, no start
        gen_en = 1'b0; lvl_hold = 1'b0; lvl_ph0 = 1'b1; lvl_ph1 = 1'b1;
        vs_rise_sel = 1'b1; hs_invert = 1'b0;
        hold_time = 11'd0; ph0_time = 11'd4; ph1_time = 11'd4;
        vsync_in = 1'b0; tick(6);
        vsync_in = 1'b1; tick(6);
        check(1'b0, "R2 disabled ignores vsync");
        hs_period(1'b0, 1'b0, "R2 disabled stays idle");

        // R9: latency with hold skipped
        gen_en = 1'b1;
        vsync_in = 1'b0; tick(6);
        @(posedge clk); #1;
        vsync_in = 1'b1;
        tick(2);
        check(1'b0, "R9 no change after second edge");
        tick(1);
        check(1'b1, "R9 change after third edge");

        // R2: abort mid-sequence
        hs_period(1'b0, 1'b1, "R7 step0 running");
        gen_en = 1'b0;
        tick(1);
        check(1'b0, "R2 abort on enable clear");
        gen_en = 1'b1;
        hs_period(1'b0, 1'b0, "R2 idle after abort");
        hs_period(1'b0, 1'b0, "R2 idle after abort");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule